// File: doc/BRIEF.md
# Program-ROM Bank Override Register

This block sits on the cartridge side next to a general-purpose memory controller and takes over program-ROM banking from it. It snoops CPU writes (16-bit address, 8-bit data). From one of the controller's registers it keeps only the RAM-window enable bit. While that bit is set, a write anywhere in 0x6000–0x7FFF loads a 4-bit bank register. The controller's own program-bank registers play no part in the mapping.

The bank register drives the upper program-ROM address bits for the two 16 KB halves of 0x8000–0xFFFF. Register bit 3 has two roles. It selects the upper 128 KB of the 256 KB ROM, and it switches between a mirrored 16 KB mapping and a 32 KB mapping. The ROM address and chip-select are combinational from the CPU address, so a new bank value applies from the first CPU access after the write.

Top module: `prg_override`

## Requirements
- R1: After reset the bank register and the captured control byte are zero: 16 KB mode on bank 0, with window writes locked out.
- R2: A strobed write with address[15:13]=3'b101 and address[0]=1 captures the control byte. Its bit 7 is the window enable. The same write with address[0]=0 changes nothing.
- R3: While the captured enable bit is 0, writes to 0x6000–0x7FFF leave the bank register unchanged.
- R4: A window write stores only data bits [3:0]. Data bits [7:4] have no effect on mapping.
- R5: With bank bit 3 = 0 (16 KB mode), both 0x8000–0xBFFF and 0xC000–0xFFFF map to ROM bank {bank[3:0]}, so prg_addr_o = {bank, cpu_addr[13:0]}.
- R6: With bank bit 3 = 1 (32 KB mode), 0x8000–0xBFFF maps to bank {bank[3:1],0} and 0xC000–0xFFFF maps to bank {bank[3:1],1}.
- R7: A bank write made at one clock edge is visible on prg_addr_o from that edge onward.
- R8: rom_cs_o is 1 exactly when cpu_addr[15]=1. prg_addr_o is zero when cpu_addr[15]=0.
- R9: Only address[15:13]=3'b011 decodes the bank register. Enabled writes elsewhere (e.g. 0x4000, 0xE000) leave it unchanged.
- R10: Address and data presented without wr_stb_i alter neither register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_stb_i | input | 1 | One-cycle CPU write strobe (write with phase 2 high) |
| cpu_addr_i | input | 16 | CPU address bus |
| cpu_data_i | input | 8 | CPU write data |
| prg_addr_o | output | 18 | Program-ROM address |
| rom_cs_o | output | 1 | Program-ROM chip select |

## Verification
Every one of the 256 data bytes is written into the window, at a spread of window offsets. After each write the mapping is read back at both edges of both 16 KB halves and at one address below 0x8000. This separates the mirrored mode from the paired 32 KB mode, shows that the high nibble is dropped, and checks the chip-select boundary. Further patterns write with the enable cleared, write to the control address with bit 0 low, write to decodes adjacent to the window, and hold address and data without a strobe. In each case the unchanged mapping distinguishes a gated write from a leaking one.

// File: rtl/prg_override_pkg.sv
package prg_override_pkg;
  parameter int unsigned CPU_AW  = 16;
  parameter int unsigned CPU_DW  = 8;
  parameter int unsigned BANK_W  = 4;
  parameter int unsigned PAGE_W  = 14;
  localparam int unsigned PRG_AW = BANK_W + PAGE_W;
  localparam int unsigned EN_BIT = 7;
  localparam logic [2:0] WIN_SEL  = 3'b011;
  localparam logic [2:0] CTRL_SEL = 3'b101;
endpackage

// File: rtl/prg_ctrl_snoop.sv
module prg_ctrl_snoop
  import prg_override_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_stb_i,
  input  logic [CPU_AW-1:0] cpu_addr_i,
  input  logic [CPU_DW-1:0] cpu_data_i,
  output logic              win_en_o
);
  logic [CPU_DW-1:0] ctrl_q;
  logic              hit;

  assign hit = wr_stb_i && (cpu_addr_i[CPU_AW-1 -: 3] == CTRL_SEL) && cpu_addr_i[0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)  ctrl_q <= '0;
    else if (hit) ctrl_q <= cpu_data_i;
  end

  assign win_en_o = ctrl_q[EN_BIT];
endmodule

// File: rtl/prg_bank_reg.sv
module prg_bank_reg
  import prg_override_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_stb_i,
  input  logic              win_en_i,
  input  logic [CPU_AW-1:0] cpu_addr_i,
  input  logic [CPU_DW-1:0] cpu_data_i,
  output logic [BANK_W-1:0] bank_o
);
  logic [BANK_W-1:0] bank_q;
  logic              load;

  assign load = wr_stb_i && win_en_i && (cpu_addr_i[CPU_AW-1 -: 3] == WIN_SEL);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   bank_q <= '0;
    else if (load) bank_q <= cpu_data_i[BANK_W-1:0];
  end

  assign bank_o = bank_q;
endmodule

// File: rtl/prg_bank_map.sv
module prg_bank_map
  import prg_override_pkg::*;
(
  input  logic [BANK_W-1:0] bank_i,
  input  logic [CPU_AW-1:0] cpu_addr_i,
  output logic [PRG_AW-1:0] prg_addr_o,
  output logic              rom_cs_o
);
  logic              wide;   // top bank bit doubles as 32 KB mode flag
  logic [BANK_W-1:0] rom_bank;

  assign wide = bank_i[BANK_W-1];

  always_comb begin
    rom_bank = bank_i;
    if (wide) rom_bank[0] = cpu_addr_i[PAGE_W];
  end

  assign rom_cs_o   = cpu_addr_i[CPU_AW-1];
  assign prg_addr_o = rom_cs_o ? {rom_bank, cpu_addr_i[PAGE_W-1:0]} : '0;
endmodule

// File: rtl/prg_override.sv
module prg_override
  import prg_override_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_stb_i,
  input  logic [CPU_AW-1:0] cpu_addr_i,
  input  logic [CPU_DW-1:0] cpu_data_i,
  output logic [PRG_AW-1:0] prg_addr_o,
  output logic              rom_cs_o
);
  logic              win_en;
  logic [BANK_W-1:0] bank;

  prg_ctrl_snoop u_snoop (
    .clk_i, .rst_ni, .wr_stb_i, .cpu_addr_i, .cpu_data_i,
    .win_en_o (win_en)
  );

  prg_bank_reg u_bank (
    .clk_i, .rst_ni, .wr_stb_i, .cpu_addr_i, .cpu_data_i,
    .win_en_i (win_en),
    .bank_o   (bank)
  );

  prg_bank_map u_map (
    .bank_i     (bank),
    .cpu_addr_i,
    .prg_addr_o,
    .rom_cs_o
  );
endmodule

// File: rtl/prg_override_chk.sv
module prg_override_chk
  import prg_override_pkg::*;
(
  input logic              clk_i,
  input logic              rst_ni,
  input logic              wr_stb_i,
  input logic [CPU_AW-1:0] cpu_addr_i,
  input logic [CPU_DW-1:0] cpu_data_i,
  input logic [PRG_AW-1:0] prg_addr_o,
  input logic              rom_cs_o,
  input logic              win_en,
  input logic [BANK_W-1:0] bank
);
  logic win_wr, ctrl_wr;
  assign win_wr  = wr_stb_i && (cpu_addr_i[15:13] == 3'b011);
  assign ctrl_wr = wr_stb_i && (cpu_addr_i[15:13] == 3'b101) && cpu_addr_i[0];

  a_r2_ctrl_capture: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctrl_wr |=> win_en == $past(cpu_data_i[7]));

  a_r3_locked: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (win_wr && !win_en) |=> $stable(bank));

  a_r4_low_nibble: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (win_wr && win_en) |=> bank == $past(cpu_data_i[3:0]));

  a_r5_mirror: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rom_cs_o && !bank[3]) |-> prg_addr_o[17:14] == bank);

  a_r6_pair: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rom_cs_o && bank[3]) |-> (prg_addr_o[17:15] == bank[3:1] && prg_addr_o[14] == cpu_addr_i[14]));

  a_r8_low_space: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cpu_addr_i[15] |-> (prg_addr_o == '0 && !rom_cs_o));

  a_r10_no_strobe: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_stb_i |=> ($stable(bank) && $stable(win_en)));
endmodule

bind prg_override prg_override_chk u_chk (
  .clk_i, .rst_ni, .wr_stb_i, .cpu_addr_i, .cpu_data_i,
  .prg_addr_o, .rom_cs_o, .win_en, .bank
);

// File: tb/prg_override_test.sv
`timescale 1ns/1ps
module prg_override_test;
  logic        clk_i = 0;
  logic        rst_ni = 0;
  logic        wr_stb_i = 0;
  logic [15:0] cpu_addr_i = '0;
  logic [7:0]  cpu_data_i = '0;
  logic [17:0] prg_addr_o;
  logic        rom_cs_o;

  int tests = 0, fails = 0;
  int exp_bank = 0;
  bit exp_en = 0;

  always #10 clk_i = ~clk_i;

  prg_override uut (.*);

  function automatic logic [17:0] model(input int bank, input logic [15:0] a);
    int mode, b;
    if (!a[15]) return '0;
    mode = (bank >> 3) & 1;
    b = a[14] ? ((bank & ~mode) | mode) : (bank & ~mode);
    return 18'((b << 14) | (a & 16'h3FFF));
  endfunction

  task automatic check(input string req, input logic [15:0] a);
    cpu_addr_i = a;
    #1;
    tests++;
    if (prg_addr_o !== model(exp_bank, a) || rom_cs_o !== a[15]) begin
      fails++;
      $display("FAIL %s addr=%h got=%h/%b exp=%h/%b", req, a, prg_addr_o, rom_cs_o,
               model(exp_bank, a), a[15]);
    end
  endtask

  task automatic wr(input logic [15:0] a, input logic [7:0] d);
    @(negedge clk_i);
    cpu_addr_i = a; cpu_data_i = d; wr_stb_i = 1;
    @(negedge clk_i);
    wr_stb_i = 0;
    if (a[15:13] == 3'b101 && a[0]) exp_en = d[7];
    if (a[15:13] == 3'b011 && exp_en) exp_bank = d & 15;
  endtask

  task automatic sweep(input string req);
    check(req, 16'h8000); check(req, 16'hBFFF);
    check(req, 16'hC123); check(req, 16'hFFFF);
    check("R8", 16'h7FFF);
  endtask

  initial begin
    #2_000_000;
    fails++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1;
    check("R1", 16'h8000); check("R1", 16'hC000);
    // R3: locked window at reset
    wr(16'h6000, 8'h0B); sweep("R3");
    // R2: even control address ignored
    wr(16'hA000, 8'h80); wr(16'h7000, 8'h05); sweep("R2");
    wr(16'hA001, 8'h80);
    // R4 R5 R6 R7: full data sweep
    for (int d = 0; d < 256; d++) begin
      wr(16'h6000 | 16'((d * 37) & 16'h1FFF), 8'(d));
      sweep((d & 8) ? "R6" : "R5");
      check("R4", 16'hC000 | 16'(d));
    end
    // R7: visible right after the capturing edge
    @(negedge clk_i);
    cpu_addr_i = 16'h7FFF; cpu_data_i = 8'h03; wr_stb_i = 1;
    @(posedge clk_i); #1; wr_stb_i = 0; exp_bank = 3;
    check("R7", 16'h8000);
    // R9: neighbouring decodes
    wr(16'h4000, 8'h0F); sweep("R9");
    wr(16'hE000, 8'h0F); sweep("R9");
    wr(16'h8001, 8'h0F); sweep("R9");
    // R10: no strobe
    @(negedge clk_i); cpu_addr_i = 16'h6000; cpu_data_i = 8'h0E;
    @(negedge clk_i); cpu_addr_i = 16'hA001; cpu_data_i = 8'h00;
    @(negedge clk_i); sweep("R10");
    wr(16'h6000, 8'h0A); sweep("R10");
    // R3: disable then try to load
    wr(16'hA001, 8'h7F); wr(16'h6ABC, 8'h01); sweep("R3");
    wr(16'hA001, 8'hFF); wr(16'h6ABC, 8'h01); sweep("R2");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule